// File: doc/BRIEF.md
# Charger Host Interrupt Pulser with Read-to-Clear Fault Latch

This block tells a host processor about changes in charger status. It does this with an active-low interrupt line that goes low for a fixed time, 256 µs. Five kinds of event start a pulse:

- the input source type is identified;
- a good input source is qualified;
- the input is taken away;
- charging completes;
- a new fault appears.

A good source requires three already-qualified conditions to be true at once:

- the supply is above the battery voltage;
- the supply is below the overvoltage limit;
- the supply holds its minimum level while a test load is applied.

Every input is a clean digital flag. If a trigger arrives while a pulse is already running, the pulse is stretched.

Faults are kept in a snapshot register. When a fault rises, the latch captures the live fault vector and stops further fault interrupts. A host read returns the snapshot and reloads the latch from the live vector, so the next read shows the present live state. Fault interrupts are armed again only when the live fault vector has fallen to all zero. The host port is a read strobe, a register-select qualifier and registered 8-bit read data.

Two state machines do the work:

- **Pulse machine.** States `PS_IDLE` and `PS_ACTIVE`. The transitions are start (idle to active on a trigger), reload (active to active on a trigger), and expire (active to idle when the count reaches zero with no trigger).
- **Fault machine.** States `FS_ARMED`, `FS_HELD` and `FS_REARM`. The transitions are:
  - capture: armed to held on a new fault bit;
  - release: held to armed on a read while the live vector is zero;
  - defer: held to rearm on a read while faults are still live;
  - clear: rearm to armed when the live vector becomes zero.

Top module: `charger_irq_ctrl`

## Requirements
- R1: `int_n` idles high. A single trigger drives it low for exactly PULSE_CYC = CLK_HZ*256/1_000_000 clock cycles, starting on the clock edge that samples the trigger. The default CLK_HZ of 250000 gives 64 cycles.
- R2: A 0-to-1 transition of `src_id_done` triggers a pulse.
- R3: A pulse is triggered only when the AND of `vbus_gt_bat`, `vbus_lt_ovp` and `vbus_load_ok` goes from 0 to 1. Any two of the three alone trigger nothing.
- R4: A 1-to-0 transition of `input_present` triggers a pulse. A 0-to-1 transition does not.
- R5: A 0-to-1 transition of `chg_done` triggers a pulse.
- R6: A trigger that arrives during a pulse restarts the count. `int_n` then stays low until PULSE_CYC cycles after the last trigger.
- R7: In the armed state, a 0-to-1 transition of any `fault_live` bit triggers a pulse and captures the live vector into the fault snapshot.
- R8: While the snapshot is held and not yet read, new fault bits trigger no pulse and do not alter the snapshot.
- R9: A read (`rd_strobe` and `rd_sel` both high) loads `rd_data` on the next edge with the snapshot, zero-extended with fault bit i at `rd_data` bit i. It also reloads the snapshot from `fault_live`, so a second consecutive read returns the live vector as it stood at the first read.
- R10: After a read, fault interrupts stay disabled until `fault_live` is all zero. Faults clearing never trigger a pulse.
- R11: A strobe with `rd_sel` low changes neither `rd_data` nor the snapshot.
- R12: Synchronous active-high `rst` leaves `int_n` high, `rd_data` zero and the snapshot zero, with the fault machine armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_id_done | input | 1 | Input source type identified |
| vbus_gt_bat | input | 1 | Supply above battery |
| vbus_lt_ovp | input | 1 | Supply below overvoltage limit |
| vbus_load_ok | input | 1 | Supply holds minimum under test load |
| input_present | input | 1 | Input source attached |
| chg_done | input | 1 | Charge cycle complete |
| fault_live | input | FAULT_W | Live fault flags |
| rd_strobe | input | 1 | Host read strobe |
| rd_sel | input | 1 | Read addresses the fault register |
| int_n | output | 1 | Active-low interrupt pulse |
| rd_data | output | 8 | Registered fault register read data |

## Verification
The bench stretches a pulse with a second trigger 20 cycles after the first and expects a low time of 84 cycles. A design that does not reload the counter would give 64 cycles. The good-source test raises two of the three conditions first; a design that ORs the conditions would pulse early. A fault-latch design that accumulates new bits while held, re-arms on the read rather than on live zero, or pulses on a clearing fault would show up in three ways: as an unexpected pulse, as the wrong first-read value (0x01 expected before 0x05), or as a non-zero read after the live vector clears. A deselected strobe is placed between a live-vector change and a real read. A design that reloads on that strobe would return zero instead of the held snapshot.

// File: rtl/charger_irq_pkg.sv
package charger_irq_pkg;
    typedef enum logic {
        PS_IDLE,
        PS_ACTIVE
    } pulse_state_t;

    typedef enum logic [1:0] {
        FS_ARMED,
        FS_HELD,
        FS_REARM
    } fault_state_t;

    localparam int RD_W = 8;
endpackage

// File: rtl/irq_edge_bank.sv
module irq_edge_bank #(
    parameter int          N         = 4,
    parameter logic [N-1:0] RISE_MASK = '1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] lvl,
    output logic         any_edge
);
    logic [N-1:0] prev_q;
    logic [N-1:0] hit;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= lvl;
    end

    for (genvar i = 0; i < N; i++) begin : g_bit
        if (RISE_MASK[i]) begin : g_rise
            assign hit[i] = lvl[i] & ~prev_q[i];
        end else begin : g_fall
            assign hit[i] = ~lvl[i] & prev_q[i];
        end
    end

    assign any_edge = |hit;
endmodule

// File: rtl/irq_pulse_gen.sv
module irq_pulse_gen
    import charger_irq_pkg::*;
#(
    parameter int PULSE_CYC = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic trig,
    output logic int_n
);
    localparam int CW = $clog2(PULSE_CYC + 1);
    localparam logic [CW-1:0] LOAD = CW'(PULSE_CYC - 1);

    pulse_state_t st_q, st_d;
    logic [CW-1:0] cnt_q, cnt_d;

    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        unique case (st_q)
            PS_IDLE: begin
                if (trig) begin
                    st_d  = PS_ACTIVE;
                    cnt_d = LOAD;
                end
            end
            PS_ACTIVE: begin
                if (trig) begin
                    cnt_d = LOAD;
                end else if (cnt_q == '0) begin
                    st_d = PS_IDLE;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            default: st_d = PS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= PS_IDLE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) int_n <= 1'b1;
        else     int_n <= (st_d != PS_ACTIVE);
    end
endmodule

// File: rtl/irq_fault_latch.sv
module irq_fault_latch
    import charger_irq_pkg::*;
#(
    parameter int FAULT_W = 5
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [FAULT_W-1:0] fault_live,
    input  logic               rd_hit,
    output logic               fault_fire,
    output logic [RD_W-1:0]    rd_data
);
    fault_state_t       st_q, st_d;
    logic [FAULT_W-1:0] prev_q;
    logic [FAULT_W-1:0] snap_q;
    logic               new_fault;
    logic               live_zero;
    logic               load_snap;

    assign new_fault = |(fault_live & ~prev_q);
    assign live_zero = (fault_live == '0);

    always_comb begin
        st_d       = st_q;
        fault_fire = 1'b0;
        load_snap  = rd_hit;
        unique case (st_q)
            FS_ARMED: begin
                if (new_fault) begin
                    fault_fire = 1'b1;
                    load_snap  = 1'b1;
                    st_d       = FS_HELD;
                end
            end
            FS_HELD: begin
                if (rd_hit) st_d = live_zero ? FS_ARMED : FS_REARM;
            end
            FS_REARM: begin
                if (live_zero) st_d = FS_ARMED;
            end
            default: st_d = FS_ARMED;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= FS_ARMED;
            prev_q <= '0;
            snap_q <= '0;
        end else begin
            st_q   <= st_d;
            prev_q <= fault_live;
            if (load_snap) snap_q <= fault_live;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)         rd_data <= '0;
        else if (rd_hit) rd_data <= RD_W'(snap_q);
    end
endmodule

// File: rtl/charger_irq_ctrl.sv
module charger_irq_ctrl
    import charger_irq_pkg::*;
#(
    parameter int CLK_HZ  = 250_000,
    parameter int FAULT_W = 5
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               src_id_done,
    input  logic               vbus_gt_bat,
    input  logic               vbus_lt_ovp,
    input  logic               vbus_load_ok,
    input  logic               input_present,
    input  logic               chg_done,
    input  logic [FAULT_W-1:0] fault_live,
    input  logic               rd_strobe,
    input  logic               rd_sel,
    output logic               int_n,
    output logic [7:0]         rd_data
);
    localparam longint PULSE_L   = (longint'(CLK_HZ) * 256) / 1_000_000;
    localparam int     PULSE_CYC = (PULSE_L < 1) ? 1 : int'(PULSE_L);

    logic good_src;
    logic status_edge;
    logic fault_fire;
    logic rd_hit;

    assign good_src = vbus_gt_bat & vbus_lt_ovp & vbus_load_ok;
    assign rd_hit   = rd_strobe & rd_sel;

    // bit order: src_id, good source, charge done (rising); input present (falling)
    irq_edge_bank #(
        .N         (4),
        .RISE_MASK (4'b0111)
    ) u_edges (
        .clk      (clk),
        .rst      (rst),
        .lvl      ({input_present, chg_done, good_src, src_id_done}),
        .any_edge (status_edge)
    );

    irq_fault_latch #(
        .FAULT_W (FAULT_W)
    ) u_fault (
        .clk        (clk),
        .rst        (rst),
        .fault_live (fault_live),
        .rd_hit     (rd_hit),
        .fault_fire (fault_fire),
        .rd_data    (rd_data)
    );

    irq_pulse_gen #(
        .PULSE_CYC (PULSE_CYC)
    ) u_pulse (
        .clk   (clk),
        .rst   (rst),
        .trig  (status_edge | fault_fire),
        .int_n (int_n)
    );
endmodule

// File: rtl/charger_irq_checker.sv
module charger_irq_checker (
    input logic       clk,
    input logic       rst,
    input logic       src_id_done,
    input logic       vbus_gt_bat,
    input logic       vbus_lt_ovp,
    input logic       vbus_load_ok,
    input logic       input_present,
    input logic       chg_done,
    input logic       rd_strobe,
    input logic       rd_sel,
    input logic       int_n,
    input logic [7:0] rd_data
);
    logic good;
    assign good = vbus_gt_bat & vbus_lt_ovp & vbus_load_ok;

    a_r2_src_id_pulses: assert property (@(posedge clk) disable iff (rst)
        $rose(src_id_done) |=> !int_n);

    a_r3_good_src_pulses: assert property (@(posedge clk) disable iff (rst)
        $rose(good) |=> !int_n);

    a_r4_removal_pulses: assert property (@(posedge clk) disable iff (rst)
        $fell(input_present) |=> !int_n);

    a_r5_chg_done_pulses: assert property (@(posedge clk) disable iff (rst)
        $rose(chg_done) |=> !int_n);

    a_r11_rd_data_hold: assert property (@(posedge clk) disable iff (rst)
        !(rd_strobe && rd_sel) |=> $stable(rd_data));

    a_r12_reset_idle: assert property (@(posedge clk)
        rst |=> (int_n && rd_data == 8'h00));
endmodule

bind charger_irq_ctrl charger_irq_checker u_irq_chk (
    .clk           (clk),
    .rst           (rst),
    .src_id_done   (src_id_done),
    .vbus_gt_bat   (vbus_gt_bat),
    .vbus_lt_ovp   (vbus_lt_ovp),
    .vbus_load_ok  (vbus_load_ok),
    .input_present (input_present),
    .chg_done      (chg_done),
    .rd_strobe     (rd_strobe),
    .rd_sel        (rd_sel),
    .int_n         (int_n),
    .rd_data       (rd_data)
);

// File: tb/test_charger_irq_ctrl.sv
module test_charger_irq_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int PW = 64;

    logic       clk = 0;
    logic       rst = 1;
    logic       src_id_done = 0, vbus_gt_bat = 0, vbus_lt_ovp = 0, vbus_load_ok = 0;
    logic       input_present = 0, chg_done = 0;
    logic [4:0] fault_live = '0;
    logic       rd_strobe = 0, rd_sel = 0;
    logic       int_n;
    logic [7:0] rd_data;

    int checks = 0;
    int errors = 0;
    int exp_q[$];
    int low_len = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    charger_irq_ctrl i_charger_irq_ctrl (
        .clk(clk), .rst(rst), .src_id_done(src_id_done), .vbus_gt_bat(vbus_gt_bat),
        .vbus_lt_ovp(vbus_lt_ovp), .vbus_load_ok(vbus_load_ok),
        .input_present(input_present), .chg_done(chg_done), .fault_live(fault_live),
        .rd_strobe(rd_strobe), .rd_sel(rd_sel), .int_n(int_n), .rd_data(rd_data)
    );

    // monitor: measure each low pulse, pop expected width
    always @(negedge clk) begin
        if (!rst) begin
            if (!int_n) low_len++;
            else if (low_len != 0) begin
                checks++;
                if (exp_q.size() == 0) begin
                    errors++;
                    $display("FAIL R1/R8/R10 unexpected pulse: actual width %0d expected none", low_len);
                end else begin
                    int e;
                    e = exp_q.pop_front();
                    if (e != low_len) begin
                        errors++;
                        $display("FAIL R1/R6 pulse width: actual %0d expected %0d", low_len, e);
                    end
                end
                low_len = 0;
            end
        end
    end

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_pulse(int w);
        exp_q.push_back(w);
    endtask

    task automatic settle(string req);
        cyc(PW + 30);
        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL %s missing pulse: actual pending %0d expected 0", req, exp_q.size());
            exp_q.delete();
        end
    endtask

    task automatic host_read(logic sel, logic [7:0] exp, string req);
        rd_strobe = 1; rd_sel = sel;
        cyc(1);
        rd_strobe = 0; rd_sel = 0;
        checks++;
        if (rd_data !== exp) begin
            errors++;
            $display("FAIL %s read data: actual %02h expected %02h", req, rd_data, exp);
        end
        cyc(1);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        cyc(4);
        rst = 0;
        cyc(1);
        // R12 reset state
        checks++;
        if (int_n !== 1'b1 || rd_data !== 8'h00) begin
            errors++;
            $display("FAIL R12 reset: actual int_n=%b rd=%02h expected 1/00", int_n, rd_data);
        end
        host_read(1, 8'h00, "R12");

        // R2 source identified
        expect_pulse(PW); src_id_done = 1; settle("R2");
        // R3 good source needs all three
        vbus_gt_bat = 1; vbus_lt_ovp = 1; settle("R3 partial");
        expect_pulse(PW); vbus_load_ok = 1; settle("R3");
        // R4 removal only
        input_present = 1; settle("R4 attach");
        expect_pulse(PW); input_present = 0; settle("R4");
        // R5 charge complete
        expect_pulse(PW); chg_done = 1; settle("R5");
        // R6 retrigger extends
        chg_done = 0; src_id_done = 0; settle("R6 falls");
        expect_pulse(PW + 20);
        chg_done = 1; cyc(20); src_id_done = 1; settle("R6");

        // R7 capture
        expect_pulse(PW); fault_live = 5'h01; settle("R7");
        // R8 no pulse while held
        fault_live = 5'h05; settle("R8");
        host_read(1, 8'h01, "R8/R9 first read");
        host_read(1, 8'h05, "R9 second read");
        // R10 not re-armed while faults live
        fault_live = 5'h0D; settle("R10 rearm wait");
        fault_live = 5'h00; settle("R10 clear");
        host_read(1, 8'h05, "R10 read");
        host_read(1, 8'h00, "R10 read zero");
        // re-armed after live zero
        expect_pulse(PW); fault_live = 5'h10; settle("R10 rearmed");
        // R11 deselected strobe
        fault_live = 5'h00; cyc(2);
        host_read(0, 8'h00, "R11 deselected");
        host_read(1, 8'h10, "R11 snapshot kept");
        host_read(1, 8'h00, "R11 live after");
        // R10 fault clearing triggers nothing
        expect_pulse(PW); fault_live = 5'h02; settle("R7 second");
        host_read(1, 8'h02, "R9 read");
        fault_live = 5'h00; settle("R10 falling fault");
        host_read(1, 8'h02, "R9 reload");
        host_read(1, 8'h00, "R9 zero");

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule